// File: doc/BRIEF.md
# Tournament Predictor Chooser

This block is the selector stage of a tournament branch direction predictor. Two component direction predictors live outside it: a global one, driven by recent branch history, and a local one, driven by the branch's own past. Every fetch cycle the block takes the branch address and both component guesses. It reads a small table of 2-bit chooser counters, indexed by low-order address bits, and returns the guess of whichever component that counter currently trusts. The lookup path is purely combinational.

When a branch resolves, the pipeline reports the branch address and whether each component guessed correctly. The chooser counter moves only when the two components disagreed in correctness. If only the global predictor was right, the counter steps toward the global side. If only the local predictor was right, it steps toward the local side. If both were right or both were wrong, the counter stays where it is. Because the counters saturate and have two levels on each side, a strongly held choice survives a single contrary result.

Top module: `pred_chooser`

## Requirements
- R1: After reset every chooser entry holds 2'b01 (weakly global), so every lookup reports `useLocal`=0 and `finalPred` equal to `globalPred`.
- R2: The entry is selected by address bits `[ALIGN+IDX_W-1:ALIGN]` (bits [5:2] by default). Address bits outside that field have no effect, and an update to one entry leaves the other entries unchanged.
- R3: The top bit of the selected entry chooses the output: 0 gives `finalPred`=`globalPred` and 1 gives `finalPred`=`localPred`, in the same cycle as the lookup inputs.
- R4: A resolve with `globalOk`=1 and `localOk`=0 decrements the entry by one, saturating at 2'b00.
- R5: A resolve with `globalOk`=0 and `localOk`=1 increments the entry by one, saturating at 2'b11.
- R6: A resolve where `globalOk` equals `localOk` (both right or both wrong) leaves the entry unchanged.
- R7: When `resolveValid`=0, no entry changes, whatever the correctness inputs are.
- R8: From a strong state (00 or 11), one contrary result only moves the entry to the weak state on the same side, so the choice is kept. A second consecutive contrary result changes the choice.
- R9: An update is written at the clock edge where `resolveValid` is sampled. A lookup of the same entry in that cycle sees the old state, and a lookup in the next cycle sees the new state.
- R10: `useLocal` equals the top bit of the selected entry: 1 when the local predictor is chosen, 0 when the global predictor is chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupAddr | input | ADDR_W | Address of the branch being predicted |
| globalPred | input | 1 | Direction guessed by the global component (1 = taken) |
| localPred | input | 1 | Direction guessed by the local component (1 = taken) |
| finalPred | output | 1 | Selected direction |
| useLocal | output | 1 | 1 when the local component was selected |
| resolveValid | input | 1 | A resolved branch is reported this cycle |
| resolveAddr | input | ADDR_W | Address of the resolved branch |
| globalOk | input | 1 | The global component guessed the resolved branch correctly |
| localOk | input | 1 | The local component guessed the resolved branch correctly |

## Verification
A wrong counter value shows at the ports only when it crosses the boundary between the two sides, because the lookup exposes only the top bit. A wrong step inside one side stays hidden until a later contrary result either flips the choice too early or fails to flip it. For that reason the bench keeps a full 2-bit model of every entry and looks up the resolved entry on the cycle right after each update. A missed or extra step then shows within one or two further resolves of that entry. A wrong index decode shows at once, as a choice change on a neighbouring entry or a missing change on the addressed one.

// File: rtl/chooser_pkg.sv
package chooser_pkg;

  typedef logic [1:0] choice_t;

  localparam choice_t CH_STRONG_GLOBAL = 2'b00;
  localparam choice_t CH_WEAK_GLOBAL   = 2'b01;
  localparam choice_t CH_WEAK_LOCAL    = 2'b10;
  localparam choice_t CH_STRONG_LOCAL  = 2'b11;

  // strobes passed from the control to the table datapath
  typedef struct packed {
    logic wrEn;        // move the addressed entry by one step
    logic towardLocal; // 1: step up toward local, 0: step down toward global
  } strobe_t;

endpackage

// File: rtl/chooser_ctrl.sv
module chooser_ctrl
  import chooser_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    resolveValid,
  input  logic    globalOk,
  input  logic    localOk,
  output strobe_t strobes
);

  logic disagree;

  always_comb begin
    disagree            = globalOk ^ localOk;
    strobes.wrEn        = resolveValid && disagree;
    strobes.towardLocal = localOk;
  end

  AST_AGREE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (resolveValid && (globalOk == localOk)) |-> !strobes.wrEn) else $error("AST_AGREE_IDLE"); // R6
  AST_INVALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !resolveValid |-> !strobes.wrEn) else $error("AST_INVALID_IDLE"); // R7

endmodule

// File: rtl/chooser_table.sv
module chooser_table
  import chooser_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] rdIdx,
  input  logic [IDX_W-1:0] wrIdx,
  input  strobe_t          strobes,
  output choice_t          rdState
);

  localparam int ENTRIES = 1 << IDX_W;

  choice_t tbl [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    choice_t cellQ;
    logic    hit;

    assign hit    = strobes.wrEn && (wrIdx == IDX_W'(e));
    assign tbl[e] = cellQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cellQ <= CH_WEAK_GLOBAL;
      end else if (hit) begin
        if (strobes.towardLocal) begin
          if (cellQ != CH_STRONG_LOCAL) cellQ <= cellQ + 2'd1;
        end else begin
          if (cellQ != CH_STRONG_GLOBAL) cellQ <= cellQ - 2'd1;
        end
      end
    end
  end

  assign rdState = tbl[rdIdx];

  // shadow of the previous cycle's write, kept only for the properties below
  logic             chkVld;
  logic             chkUp;
  logic [IDX_W-1:0] chkIdx;
  choice_t          chkOld;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chkVld <= 1'b0;
      chkUp  <= 1'b0;
      chkIdx <= '0;
      chkOld <= CH_WEAK_GLOBAL;
    end else begin
      chkVld <= strobes.wrEn;
      chkUp  <= strobes.towardLocal;
      chkIdx <= wrIdx;
      chkOld <= tbl[wrIdx];
    end
  end

  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rstN)
    (chkVld && chkUp && chkOld != CH_STRONG_LOCAL) |-> tbl[chkIdx] == chkOld + 2'd1) else $error("AST_STEP_UP"); // R5
  AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (chkVld && chkUp && chkOld == CH_STRONG_LOCAL) |-> tbl[chkIdx] == CH_STRONG_LOCAL) else $error("AST_SAT_TOP"); // R5
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (chkVld && !chkUp && chkOld != CH_STRONG_GLOBAL) |-> tbl[chkIdx] == chkOld - 2'd1) else $error("AST_STEP_DOWN"); // R4
  AST_SAT_BOTTOM: assert property (@(posedge clk) disable iff (!rstN)
    (chkVld && !chkUp && chkOld == CH_STRONG_GLOBAL) |-> tbl[chkIdx] == CH_STRONG_GLOBAL) else $error("AST_SAT_BOTTOM"); // R4
  AST_STRONG_KEEPS_SIDE: assert property (@(posedge clk) disable iff (!rstN)
    (chkVld && (chkOld == CH_STRONG_LOCAL || chkOld == CH_STRONG_GLOBAL)) |-> tbl[chkIdx][1] == chkOld[1]) else $error("AST_STRONG_KEEPS_SIDE"); // R8

endmodule

// File: rtl/pred_chooser.sv
module pred_chooser
  import chooser_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  parameter int ALIGN  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] lookupAddr,
  input  logic              globalPred,
  input  logic              localPred,
  output logic              finalPred,
  output logic              useLocal,
  input  logic              resolveValid,
  input  logic [ADDR_W-1:0] resolveAddr,
  input  logic              globalOk,
  input  logic              localOk
);

  strobe_t          strobes;
  choice_t          rdState;
  logic [IDX_W-1:0] rdIdx;
  logic [IDX_W-1:0] wrIdx;

  assign rdIdx = lookupAddr[ALIGN +: IDX_W];
  assign wrIdx = resolveAddr[ALIGN +: IDX_W];

  chooser_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .resolveValid (resolveValid),
    .globalOk     (globalOk),
    .localOk      (localOk),
    .strobes      (strobes)
  );

  chooser_table #(.IDX_W(IDX_W)) u_table (
    .clk     (clk),
    .rstN    (rstN),
    .rdIdx   (rdIdx),
    .wrIdx   (wrIdx),
    .strobes (strobes),
    .rdState (rdState)
  );

  assign useLocal  = rdState[1];
  assign finalPred = useLocal ? localPred : globalPred;

  AST_PICK_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    finalPred == (useLocal ? localPred : globalPred)) else $error("AST_PICK_SOURCE"); // R3

endmodule

// File: tb/pred_chooser_test.sv
module pred_chooser_test;

  localparam int PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 4;
  localparam int ALIGN  = 2;
  localparam int ENTRIES = 1 << IDX_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] lookupAddr = '0;
  logic globalPred = 1'b0;
  logic localPred = 1'b0;
  logic finalPred;
  logic useLocal;
  logic resolveValid = 1'b0;
  logic [ADDR_W-1:0] resolveAddr = '0;
  logic globalOk = 1'b0;
  logic localOk = 1'b0;

  int checks = 0;
  int errors = 0;
  int expState [ENTRIES];
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  pred_chooser #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN(ALIGN)) uut (
    .clk(clk), .rstN(rstN), .lookupAddr(lookupAddr), .globalPred(globalPred),
    .localPred(localPred), .finalPred(finalPred), .useLocal(useLocal),
    .resolveValid(resolveValid), .resolveAddr(resolveAddr),
    .globalOk(globalOk), .localOk(localOk)
  );

  function automatic logic [ADDR_W-1:0] mkAddr(int idx, int salt);
    logic [ADDR_W-1:0] a;
    a = ADDR_W'(salt) * 32'h9E37_79B1;
    a[ALIGN +: IDX_W] = IDX_W'(idx);
    return a;
  endfunction

  task automatic lookCheck(int idx, int salt, logic g, logic l, string tag);
    logic expUse, expPred;
    lookupAddr = mkAddr(idx, salt);
    globalPred = g;
    localPred  = l;
    #1;
    expUse  = (expState[idx] >= 2);
    expPred = expUse ? l : g;
    checks++;
    if (useLocal !== expUse || finalPred !== expPred) begin
      errors++;
      $display("FAIL %s entry %0d: useLocal=%b finalPred=%b expected useLocal=%b finalPred=%b",
               tag, idx, useLocal, finalPred, expUse, expPred);
    end
  endtask

  // drive at the falling edge, commit at the rising edge, update the model
  task automatic resolve(int idx, int salt, logic vld, logic gOk, logic lOk);
    @(negedge clk);
    resolveValid = vld;
    resolveAddr  = mkAddr(idx, salt);
    globalOk     = gOk;
    localOk      = lOk;
    @(posedge clk);
    if (vld && (gOk != lOk)) begin
      if (lOk) expState[idx] = (expState[idx] == 3) ? 3 : expState[idx] + 1;
      else     expState[idx] = (expState[idx] == 0) ? 0 : expState[idx] - 1;
    end
    #1;
    resolveValid = 1'b0;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < ENTRIES; i++) expState[i] = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state, all entries weakly global
    for (int i = 0; i < ENTRIES; i++) lookCheck(i, i, 1'b1, 1'b0, "R1");

    // R8: hysteresis walk on entry 5
    @(negedge clk);
    resolve(5, 1, 1'b1, 1'b0, 1'b1); @(negedge clk); lookCheck(5, 2, 1'b0, 1'b1, "R5"); // 01->10
    resolve(5, 3, 1'b1, 1'b0, 1'b1); @(negedge clk); lookCheck(5, 4, 1'b0, 1'b1, "R5"); // ->11
    resolve(5, 5, 1'b1, 1'b0, 1'b1); @(negedge clk); lookCheck(5, 6, 1'b1, 1'b0, "R5"); // sat 11
    resolve(5, 7, 1'b1, 1'b1, 1'b0); @(negedge clk); lookCheck(5, 8, 1'b1, 1'b0, "R8"); // 11->10 still local
    resolve(5, 9, 1'b1, 1'b1, 1'b0); @(negedge clk); lookCheck(5, 10, 1'b1, 1'b0, "R8"); // ->01 global
    resolve(5, 11, 1'b1, 1'b1, 1'b0); @(negedge clk); lookCheck(5, 12, 1'b0, 1'b1, "R4"); // ->00
    resolve(5, 13, 1'b1, 1'b1, 1'b0); @(negedge clk); lookCheck(5, 14, 1'b0, 1'b1, "R4"); // sat 00
    resolve(5, 15, 1'b1, 1'b0, 1'b1); @(negedge clk); lookCheck(5, 16, 1'b0, 1'b1, "R8"); // 00->01 still global
    resolve(5, 17, 1'b1, 1'b0, 1'b1); @(negedge clk); lookCheck(5, 18, 1'b0, 1'b1, "R10"); // ->10 local

    // R2: entry 3 moved, neighbours and alias bits
    resolve(3, 20, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    lookCheck(3, 21, 1'b1, 1'b0, "R2");
    lookCheck(3, 22, 1'b0, 1'b1, "R2");
    lookCheck(2, 23, 1'b1, 1'b0, "R2");
    lookCheck(4, 24, 1'b1, 1'b0, "R2");

    // R9: same-cycle lookup sees old state, next cycle sees new
    @(negedge clk);
    lookupAddr = mkAddr(9, 30);
    globalPred = 1'b1; localPred = 1'b0;
    resolveValid = 1'b1; resolveAddr = mkAddr(9, 31); globalOk = 1'b0; localOk = 1'b1;
    #1;
    checks++;
    if (useLocal !== 1'b0) begin
      errors++;
      $display("FAIL R9 same cycle: useLocal=%b expected 0", useLocal);
    end
    resolveValid = 1'b0; // hold until the edge is not needed: re-drive below
    resolveValid = 1'b1;
    @(posedge clk);
    expState[9] = 2;
    #1 resolveValid = 1'b0;
    @(negedge clk);
    lookCheck(9, 32, 1'b1, 1'b0, "R9");

    // Sweep over every entry with a mix of resolve patterns
    for (int idx = 0; idx < ENTRIES; idx++) begin
      for (int step = 0; step < 12; step++) begin
        int pick;
        logic vld, gOk, lOk;
        string tag;
        pick = (idx * 5 + step * 3 + step / 4) % 4;
        vld  = (step % 5) != 4;
        gOk  = pick[0];
        lOk  = pick[1];
        if (!vld)            tag = "R7";
        else if (gOk == lOk) tag = "R6";
        else if (gOk)        tag = "R4";
        else                 tag = "R5";
        resolve(idx, idx * 16 + step, vld, gOk, lOk);
        @(negedge clk);
        lookCheck(idx, step + 100, step[0], ~step[0], tag);
      end
    end

    // R3 / R10: every entry, every pair of component guesses
    for (int idx = 0; idx < ENTRIES; idx++) begin
      for (int c = 0; c < 4; c++) begin
        lookCheck(idx, idx + c * 7, c[0], c[1], "R3");
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule